// File: doc/BRIEF.md
# Logical Device Activation and I/O Range-Check Registers

This block holds the configuration registers of one logical device on a plug-and-play expansion card. These are an activate bit, a range-check control, a set of 16-bit I/O base windows, two interrupt selections and two DMA channel selections. A configuration agent reaches them through an 8-bit register index with write data and a write strobe. Writes are accepted only while the card is in its configuration state, which the `cfg_sel` input signals. Register readback is combinational from the index.

On the bus side, the block compares every I/O cycle address with each programmed base window, each `WIN_LEN` bytes long. When the device is active, a hit in any window raises `dev_hit` so that the device function can claim the cycle. When the device is inactive and range check is enabled, a read that hits a window is answered by the block itself with a fixed test byte, 0x55 or 0xAA. Software uses this to find conflicts before it enables the device. A clear input returns every register to zero.

Top module: `ldev_cfg_block`

## Requirements
- R1: A register write takes place only on a clock edge where both `reg_we` and `cfg_sel` are high, and it is visible on `reg_rdata` from the next cycle. `reg_rdata` always shows the register selected by `reg_idx`.
- R2: Index 0x30 holds the activate bit in bit 0. Bits 7:1 of that index read as zero.
- R3: In index 0x31, bit 1 enables range check and bit 0 selects the test byte (1 gives 0x55, 0 gives 0xAA). Bits 7:2 read as zero.
- R4: I/O window i (0 ≤ i < `NUM_IO`) keeps its base high byte at index 0x60+2i and its low byte at index 0x61+2i.
- R5: Interrupt entry j (j = 0,1) keeps its level in bits 3:0 of index 0x70+2j, where 0 means unused and upper bits read zero. Its mode is at index 0x71+2j, with bit 1 as polarity (1 = high) and bit 0 as type (1 = level). Upper bits read zero.
- R6: DMA selection j (j = 0,1) is bits 2:0 of index 0x74+j, where the value 4 means no channel is in use. Upper bits read zero.
- R7: Unimplemented indices read as zero. A write to them changes no implemented register. This includes the slots of windows at or beyond `NUM_IO`.
- R8: An address hits window i when base_i ≤ addr ≤ base_i + `WIN_LEN` − 1. The upper bound is computed without wrapping past 0xFFFF.
- R9: `dev_hit` is high exactly when the device is active, `bus_rd` or `bus_wr` is high, and the address hits a window.
- R10: While the device is inactive with range check enabled, a `bus_rd` that hits a window raises `bus_rdata_oe` with the selected test byte on `bus_rdata`. Bus writes and misses never drive. `bus_rdata` is zero whenever it is not driven.
- R11: When both activate and range check are set, activate wins: `dev_hit` behaves as in R9 and no test byte is driven.
- R12: A cycle with `clr_cfg` high clears every register to zero at the next edge. It takes priority over a write in the same cycle.
- R13: After `rst_n` is asserted, every register reads zero and neither bus output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | Card is in configuration state; qualifies writes |
| clr_cfg | input | 1 | Synchronous clear of all registers |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Readback of the indexed register |
| bus_addr | input | 16 | Bus I/O address |
| bus_rd | input | 1 | Bus I/O read strobe |
| bus_wr | input | 1 | Bus I/O write strobe |
| dev_hit | output | 1 | Active device decodes this cycle |
| bus_rdata_oe | output | 1 | Block drives a test byte |
| bus_rdata | output | 8 | Test byte, zero when not driven |

## Verification
A wrong stored bit shows on `reg_rdata` as soon as its index is selected, one cycle after the write that set it. A corrupted base or activate bit shows on the very cycle of the next bus access, as a `dev_hit` or a test byte at the wrong address or with the wrong value. The boundary addresses base and base + `WIN_LEN` − 1, together with their neighbours just outside the window, expose comparison slips of one. A window placed at the top of the address space exposes a bound that wraps.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] IDX_RCHK = 8'h31;
  localparam logic [7:0] IDX_IO   = 8'h60;
  localparam logic [7:0] IDX_IRQ  = 8'h70;
  localparam logic [7:0] IDX_DMA  = 8'h74;
  localparam int IRQ_N = 2;
  localparam int DMA_N = 2;

  // inclusive window test, bound held in 17 bits so it never wraps
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int unsigned len);
    logic [16:0] top;
    top = {1'b0, base} + 17'(len) - 17'd1;
    return ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} <= top);
  endfunction

  function automatic logic [7:0] probe_byte(input logic pat);
    return pat ? 8'h55 : 8'hAA;
  endfunction
endpackage

// File: rtl/ldev_regfile.sv
module ldev_regfile
  import ldev_pkg::*;
#(
  parameter int NUM_IO = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [7:0]              idx,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    act_q,
  output logic                    rc_en_q,
  output logic                    rc_pat_q,
  output logic [NUM_IO-1:0][15:0] io_base_q
);
  logic [3:0] irq_lvl  [IRQ_N];
  logic [1:0] irq_mode [IRQ_N];
  logic [2:0] dma_sel  [DMA_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; rc_en_q <= 1'b0; rc_pat_q <= 1'b0;
      io_base_q <= '0;
      for (int j = 0; j < IRQ_N; j++) begin irq_lvl[j] <= '0; irq_mode[j] <= '0; end
      for (int j = 0; j < DMA_N; j++) dma_sel[j] <= '0;
    end else if (clr) begin
      act_q <= 1'b0; rc_en_q <= 1'b0; rc_pat_q <= 1'b0;
      io_base_q <= '0;
      for (int j = 0; j < IRQ_N; j++) begin irq_lvl[j] <= '0; irq_mode[j] <= '0; end
      for (int j = 0; j < DMA_N; j++) dma_sel[j] <= '0;
    end else if (wr_en) begin
      if (idx == IDX_ACT) act_q <= wdata[0];
      if (idx == IDX_RCHK) begin rc_en_q <= wdata[1]; rc_pat_q <= wdata[0]; end
      for (int i = 0; i < NUM_IO; i++) begin
        if (idx == 8'(IDX_IO + 8'(2*i)))     io_base_q[i][15:8] <= wdata;
        if (idx == 8'(IDX_IO + 8'(2*i + 1))) io_base_q[i][7:0]  <= wdata;
      end
      for (int j = 0; j < IRQ_N; j++) begin
        if (idx == 8'(IDX_IRQ + 8'(2*j)))     irq_lvl[j]  <= wdata[3:0];
        if (idx == 8'(IDX_IRQ + 8'(2*j + 1))) irq_mode[j] <= wdata[1:0];
      end
      for (int j = 0; j < DMA_N; j++)
        if (idx == 8'(IDX_DMA + 8'(j))) dma_sel[j] <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_ACT)  rdata = {7'b0, act_q};
    if (idx == IDX_RCHK) rdata = {6'b0, rc_en_q, rc_pat_q};
    for (int i = 0; i < NUM_IO; i++) begin
      if (idx == 8'(IDX_IO + 8'(2*i)))     rdata = io_base_q[i][15:8];
      if (idx == 8'(IDX_IO + 8'(2*i + 1))) rdata = io_base_q[i][7:0];
    end
    for (int j = 0; j < IRQ_N; j++) begin
      if (idx == 8'(IDX_IRQ + 8'(2*j)))     rdata = {4'b0, irq_lvl[j]};
      if (idx == 8'(IDX_IRQ + 8'(2*j + 1))) rdata = {6'b0, irq_mode[j]};
    end
    for (int j = 0; j < DMA_N; j++)
      if (idx == 8'(IDX_DMA + 8'(j))) rdata = {5'b0, dma_sel[j]};
  end
endmodule

// File: rtl/ldev_range_dec.sv
module ldev_range_dec
  import ldev_pkg::*;
#(
  parameter int NUM_IO  = 2,
  parameter int WIN_LEN = 8
) (
  input  logic [15:0]             addr,
  input  logic [NUM_IO-1:0][15:0] bases,
  output logic [NUM_IO-1:0]       win_hit,
  output logic                    any_hit
);
  for (genvar i = 0; i < NUM_IO; i++) begin : g_win
    assign win_hit[i] = in_window(addr, bases[i], WIN_LEN);
  end
  assign any_hit = |win_hit;
endmodule

// File: rtl/ldev_bus_resp.sv
module ldev_bus_resp
  import ldev_pkg::*;
(
  input  logic       act,
  input  logic       rc_en,
  input  logic       rc_pat,
  input  logic       any_hit,
  input  logic       bus_rd,
  input  logic       bus_wr,
  output logic       probe_on,
  output logic       dev_hit,
  output logic       drive,
  output logic [7:0] data
);
  // range check is live only for an inactive device
  assign probe_on = rc_en && !act;
  assign dev_hit  = act && any_hit && (bus_rd || bus_wr);
  assign drive    = probe_on && any_hit && bus_rd;
  assign data     = drive ? probe_byte(rc_pat) : 8'h00;
endmodule

// File: rtl/ldev_cfg_block.sv
module ldev_cfg_block
  import ldev_pkg::*;
#(
  parameter int NUM_IO  = 2,
  parameter int WIN_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        clr_cfg,
  input  logic [7:0]  reg_idx,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  output logic        dev_hit,
  output logic        bus_rdata_oe,
  output logic [7:0]  bus_rdata
);
  logic                    act_q, rc_en_q, rc_pat_q;
  logic [NUM_IO-1:0][15:0] io_base_q;
  logic [NUM_IO-1:0]       win_hit;
  logic                    any_hit, probe_on, wr_ok;

  assign wr_ok = reg_we && cfg_sel;

  ldev_regfile #(.NUM_IO(NUM_IO)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr_cfg), .wr_en(wr_ok),
    .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
    .act_q(act_q), .rc_en_q(rc_en_q), .rc_pat_q(rc_pat_q),
    .io_base_q(io_base_q)
  );

  ldev_range_dec #(.NUM_IO(NUM_IO), .WIN_LEN(WIN_LEN)) u_dec (
    .addr(bus_addr), .bases(io_base_q), .win_hit(win_hit), .any_hit(any_hit)
  );

  ldev_bus_resp u_resp (
    .act(act_q), .rc_en(rc_en_q), .rc_pat(rc_pat_q), .any_hit(any_hit),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .probe_on(probe_on),
    .dev_hit(dev_hit), .drive(bus_rdata_oe), .data(bus_rdata)
  );
endmodule

// File: rtl/ldev_cfg_chk.sv
module ldev_cfg_chk #(
  parameter int NUM_IO = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_sel,
  input logic                    clr_cfg,
  input logic                    reg_we,
  input logic [7:0]              reg_idx,
  input logic [7:0]              reg_wdata,
  input logic                    bus_rd,
  input logic                    bus_wr,
  input logic                    dev_hit,
  input logic                    bus_rdata_oe,
  input logic [7:0]              bus_rdata,
  input logic                    act_q,
  input logic                    rc_en_q,
  input logic                    any_hit,
  input logic [NUM_IO-1:0][15:0] io_base_q
);
  a_r1_hold_outside_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel && !clr_cfg) |=> ($stable(act_q) && $stable(rc_en_q) && $stable(io_base_q)));

  a_r2_act_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && reg_we && !clr_cfg && reg_idx == 8'h30) |=> (act_q == $past(reg_wdata[0])));

  a_r9_hit_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    dev_hit |-> (act_q && any_hit && (bus_rd || bus_wr)));

  a_r10_drive_cond: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> (bus_rd && rc_en_q && any_hit));

  a_r10_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> (bus_rdata == 8'h55 || bus_rdata == 8'hAA));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> (bus_rdata == 8'h00));

  a_r11_active_wins: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !bus_rdata_oe);

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cfg |=> (!act_q && !rc_en_q && io_base_q == '0));
endmodule

bind ldev_cfg_block ldev_cfg_chk #(.NUM_IO(NUM_IO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .clr_cfg(clr_cfg),
  .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .dev_hit(dev_hit),
  .bus_rdata_oe(bus_rdata_oe), .bus_rdata(bus_rdata),
  .act_q(act_q), .rc_en_q(rc_en_q), .any_hit(any_hit), .io_base_q(io_base_q)
);

// File: tb/ldev_cfg_block_test.sv
module ldev_cfg_block_test;
  localparam int CLK_P   = 10;
  localparam int NUM_IO  = 2;
  localparam int WIN_LEN = 8;
  localparam int NVEC    = 17;
  // {index, write data, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h30FF01, 24'h300000, 24'h31FF03, 24'h310101,
    24'h601212, 24'h613434, 24'h62ABAB, 24'h63CDCD,
    24'h70FF0F, 24'h71FF03, 24'h720505, 24'h730202,
    24'h74FF07, 24'h750404, 24'h647700, 24'h32FF00, 24'h76FF00
  };

  logic clk = 0, rst_n = 0, cfg_sel = 0, clr_cfg = 0, reg_we = 0;
  logic [7:0] reg_idx = 0, reg_wdata = 0, reg_rdata;
  logic [15:0] bus_addr = 0;
  logic bus_rd = 0, bus_wr = 0, dev_hit, bus_rdata_oe;
  logic [7:0] bus_rdata;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ldev_cfg_block #(.NUM_IO(NUM_IO), .WIN_LEN(WIN_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .clr_cfg(clr_cfg),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .dev_hit(dev_hit), .bus_rdata_oe(bus_rdata_oe),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] idx);
    if (idx == 8'h30) return "R2";
    if (idx == 8'h31) return "R3";
    if (idx >= 8'h60 && idx < 8'(8'h60 + 2*NUM_IO)) return "R4";
    if (idx >= 8'h70 && idx <= 8'h73) return "R5";
    if (idx == 8'h74 || idx == 8'h75) return "R6";
    return "R7";
  endfunction

  task automatic wr(input logic [7:0] idx, input logic [7:0] d, input logic sel = 1);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1; cfg_sel = sel;
    @(negedge clk);
    reg_we = 0; cfg_sel = 0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk);
    reg_idx = idx;
    #1 v = reg_rdata;
  endtask

  task automatic bus(input logic [15:0] a, input logic r, input logic w);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w;
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    rd(8'h30, v); check("R13 act", {8'h0, v}, 16'h0);
    rd(8'h60, v); check("R13 base", {8'h0, v}, 16'h0);
    bus(16'h0003, 1, 0);
    check("R13 dev_hit", {15'h0, dev_hit}, 16'h0);
    check("R13 oe", {15'h0, bus_rdata_oe}, 16'h0);
    bus(16'h0, 0, 0);

    // R1 write ignored outside configuration state
    wr(8'h30, 8'h01, 0);
    rd(8'h30, v); check("R1 no cfg_sel", {8'h0, v}, 16'h0);

    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], v);
      check(tag_of(VEC[k][23:16]), {8'h0, v}, {8'h0, VEC[k][7:0]});
    end
    // R7: the unimplemented writes above left these intact
    rd(8'h31, v); check("R7 rchk kept", {8'h0, v}, 16'h0001);
    rd(8'h60, v); check("R7 base kept", {8'h0, v}, 16'h0012);

    // R8, R9 decode with device active; base0=1234, base1=ABCD
    wr(8'h30, 8'h01);
    bus(16'h1234, 1, 0); check("R9 low edge", {15'h0, dev_hit}, 16'h1);
    bus(16'h123B, 0, 1); check("R8 high edge", {15'h0, dev_hit}, 16'h1);
    bus(16'h123C, 1, 0); check("R8 above", {15'h0, dev_hit}, 16'h0);
    bus(16'h1233, 1, 0); check("R8 below", {15'h0, dev_hit}, 16'h0);
    bus(16'hABD0, 1, 0); check("R8 window1", {15'h0, dev_hit}, 16'h1);
    bus(16'h1236, 0, 0); check("R9 no strobe", {15'h0, dev_hit}, 16'h0);

    // R11 both set: active wins
    wr(8'h31, 8'h03);
    bus(16'h1236, 1, 0);
    check("R11 oe", {15'h0, bus_rdata_oe}, 16'h0);
    check("R11 hit", {15'h0, dev_hit}, 16'h1);

    // R10 probe while inactive
    wr(8'h30, 8'h00);
    bus(16'h1235, 1, 0);
    check("R10 oe", {15'h0, bus_rdata_oe}, 16'h1);
    check("R10 data55", {8'h0, bus_rdata}, 16'h0055);
    check("R10 no dev_hit", {15'h0, dev_hit}, 16'h0);
    wr(8'h31, 8'h02);
    bus(16'h1235, 1, 0); check("R10 dataAA", {8'h0, bus_rdata}, 16'h00AA);
    bus(16'h1235, 0, 1); check("R10 write no drive", {15'h0, bus_rdata_oe}, 16'h0);
    bus(16'h1240, 1, 0); check("R10 miss", {8'h0, bus_rdata}, 16'h0);
    wr(8'h31, 8'h01);
    bus(16'h1235, 1, 0); check("R10 disabled", {15'h0, bus_rdata_oe}, 16'h0);
    bus(16'h0, 0, 0);

    // R8 no wrap at top of address space
    wr(8'h62, 8'hFF); wr(8'h63, 8'hFC); wr(8'h30, 8'h01);
    bus(16'hFFFF, 1, 0); check("R8 top", {15'h0, dev_hit}, 16'h1);
    bus(16'h0000, 1, 0); check("R8 no wrap", {15'h0, dev_hit}, 16'h0);
    bus(16'h0, 0, 0);

    // R12 clear wins over a concurrent write
    @(negedge clk);
    clr_cfg = 1; cfg_sel = 1; reg_we = 1; reg_idx = 8'h31; reg_wdata = 8'h03;
    @(negedge clk);
    clr_cfg = 0; cfg_sel = 0; reg_we = 0;
    rd(8'h30, v); check("R12 act", {8'h0, v}, 16'h0);
    rd(8'h31, v); check("R12 rchk", {8'h0, v}, 16'h0);
    rd(8'h62, v); check("R12 base", {8'h0, v}, 16'h0);
    rd(8'h74, v); check("R12 dma", {8'h0, v}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule